// File: doc/BRIEF.md
# Unified 8051 Memory Space Decoder

This block sits between an 8051-class CPU core and the physical memories of a small system-on-chip. The CPU names an access by one of four spaces: program code, internal data, special-function registers and external data. It can also name a single bit. The block turns each access into one address on a single 16-bit unified map that holds flash, SRAM and a 256-byte hardware register window. Program code and external data decode to the same physical locations, so code can run from SRAM and a DMA engine can reach every memory through one map.

Code and external data share one bus. A data-port access in either of those spaces therefore takes the bus away from the instruction prefetcher for that cycle, and prefetch gets it back the cycle after. Flash cannot be written through this path. Such a write is dropped and flagged for one cycle, while writes to every other region go through. The flash size, SRAM size and register window base are parameters, so the same decoder serves each size combination.

Top module: `umd_top`

## Requirements
- R1: While reset is low and in the first cycle after it, out_valid, out_we and out_wr_ignored are 0.
- R2: With acc_bit=0 and acc_space CODE (0) or XDATA (3), out_addr equals acc_addr. out_region is 1 (flash) for addresses below FLASH_KB*1024. It is 3 (registers) from REG_BASE to REG_BASE+0xFF. It is 2 (SRAM) from 0x10000-SRAM_KB*1024 to 0xFFFF. It is 0 (unmapped) everywhere else.
- R3: With acc_space DATA (1), acc_bit=0 and acc_addr[7]=0, out_addr is 0xFF00+acc_addr[7:0] in SRAM, whatever acc_indirect holds.
- R4: With acc_space DATA, acc_bit=0 and acc_addr[7]=1, an indirect access (acc_indirect=1) gives 0xFF00+acc_addr[7:0] in SRAM. A direct access gives REG_BASE+acc_addr[7:0] in the register region, which is the SFR at that address.
- R5: With acc_space SFR (2) and acc_bit=0, the 7-bit offset acc_addr[6:0] maps to REG_BASE+0x80+acc_addr[6:0] in the register region.
- R6: With acc_bit=1 and bit address b=acc_addr[7:0] below 0x80, out_addr is 0xFF20+b[6:3], out_bit_en is 1 and out_bit_idx is b[2:0]. Space and acc_indirect have no effect.
- R7: With acc_bit=1 and b of 0x80 or above, out_addr is REG_BASE+(b & 0xF8), out_bit_en is 1 and out_bit_idx is b[2:0].
- R8: The decoded outputs appear one cycle after the acc_req cycle, with out_valid=1. In a cycle after one with no request, out_valid is 0. Byte accesses give out_bit_en=0.
- R9: pf_stall is 1 in the same cycle as acc_req=1 with acc_bit=0 and acc_space CODE or XDATA. In every other cycle it is 0. pf_grant equals pf_req && !pf_stall, so a data-port code or external-data request wins over a simultaneous prefetch.
- R10: A write (acc_wr=1) whose unified address falls in flash gives out_we=0 and out_wr_ignored=1. The flag is high only in that one output cycle.
- R11: A write whose unified address is outside flash gives out_we=1 and out_wr_ignored=0. A read gives out_we=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_req | input | 1 | Data-port access request this cycle |
| acc_space | input | 2 | Space: 0 CODE, 1 DATA, 2 SFR, 3 XDATA |
| acc_addr | input | 16 | Access address (low 8 or 7 bits for DATA, SFR and bit accesses) |
| acc_indirect | input | 1 | 1 for indirect addressing of DATA |
| acc_wr | input | 1 | 1 for write or read-modify-write, 0 for read |
| acc_bit | input | 1 | 1 for a single-bit access, with the bit address in acc_addr[7:0] |
| pf_req | input | 1 | Instruction prefetch wants the shared bus |
| pf_stall | output | 1 | Prefetch held off this cycle |
| pf_grant | output | 1 | Prefetch owns the shared bus this cycle |
| out_valid | output | 1 | Decoded access valid |
| out_addr | output | 16 | Unified address |
| out_region | output | 2 | 0 unmapped, 1 flash, 2 SRAM, 3 registers |
| out_bit_en | output | 1 | Access targets a single bit |
| out_bit_idx | output | 3 | Bit position within the byte |
| out_we | output | 1 | Write enable passed to the selected region |
| out_wr_ignored | output | 1 | One-cycle pulse for a dropped flash write |

## Verification
The properties assume the parameters form a legal map, meaning flash below the register window and the window below SRAM. The elaboration checks enforce this. They also assume the inputs are known, steady values sampled at the clock edge. The bench changes inputs only on the falling edge and holds each one for exactly one cycle, with idle cycles between groups. Every access uses one of the four space codes. Prefetch requests arrive both together with and apart from data-port code and external-data requests, so the arbitration is seen from both sides.

// File: rtl/umd_pkg.sv
package umd_pkg;
   typedef enum logic [1:0] {
      SP_CODE  = 2'd0,
      SP_DATA  = 2'd1,
      SP_SFR   = 2'd2,
      SP_XDATA = 2'd3
   } space_e;

   typedef enum logic [1:0] {
      RG_NONE  = 2'd0,
      RG_FLASH = 2'd1,
      RG_SRAM  = 2'd2,
      RG_REGS  = 2'd3
   } region_e;
endpackage

// File: rtl/umd_space_map.sv
module umd_space_map
   import umd_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int REG_BASE = 16'hDF00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  space_e            space,
   input  logic [ADDR_W-1:0] addr,
   input  logic              indirect,
   input  logic              bit_acc,
   output logic [ADDR_W-1:0] uaddr,
   output logic              bit_en,
   output logic [2:0]        bit_idx
);
   localparam int PAD_W = ADDR_W - 8;
   localparam logic [ADDR_W-1:0] REG_V  = ADDR_W'(REG_BASE);
   localparam logic [ADDR_W-1:0] DATA_V = {{PAD_W{1'b1}}, 8'h00};
   localparam logic [ADDR_W-1:0] SFR_LO = ADDR_W'(REG_BASE + 128);
   localparam logic [ADDR_W-1:0] SFR_HI = ADDR_W'(REG_BASE + 255);
   localparam logic [ADDR_W-1:0] BIT_LO = DATA_V | ADDR_W'(8'h20);
   localparam logic [ADDR_W-1:0] BIT_HI = DATA_V | ADDR_W'(8'h2F);

   logic [7:0] lo;
   assign lo = addr[7:0];

   always_comb begin
      bit_en  = 1'b0;
      bit_idx = 3'd0;
      uaddr   = addr;
      if (bit_acc) begin
         bit_en  = 1'b1;
         bit_idx = lo[2:0];
         if (!lo[7]) uaddr = DATA_V | {{PAD_W{1'b0}}, 4'h2, lo[6:3]};
         else        uaddr = REG_V  | {{PAD_W{1'b0}}, lo[7:3], 3'b000};
      end else begin
         unique case (space)
            SP_CODE, SP_XDATA: uaddr = addr;
            SP_SFR:            uaddr = REG_V | {{PAD_W{1'b0}}, 1'b1, lo[6:0]};
            SP_DATA: begin
               if (!indirect && lo[7]) uaddr = REG_V  | {{PAD_W{1'b0}}, lo};
               else                    uaddr = DATA_V | {{PAD_W{1'b0}}, lo};
            end
            default:           uaddr = addr;
         endcase
      end
   end

   AST_SFR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !bit_acc && space == SP_SFR) |-> (uaddr >= SFR_LO && uaddr <= SFR_HI)); // R5
   AST_LOW_DATA_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !bit_acc && space == SP_DATA && !addr[7]) |-> (uaddr[ADDR_W-1:8] == {PAD_W{1'b1}})); // R3
   AST_LOW_BIT_AREA: assert property (@(posedge clk) disable iff (!rst_n)
      (req && bit_acc && !addr[7]) |-> (uaddr >= BIT_LO && uaddr <= BIT_HI)); // R6
endmodule

// File: rtl/umd_region.sv
module umd_region
   import umd_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int FLASH_BYTES = 32768,
   parameter int SRAM_BYTES  = 4096,
   parameter int REG_BASE    = 16'hDF00
) (
   input  logic [ADDR_W-1:0] uaddr,
   output region_e           region
);
   localparam int SRAM_BASE = (2 ** ADDR_W) - SRAM_BYTES;
   localparam logic [ADDR_W:0] FL_END = (ADDR_W+1)'(FLASH_BYTES);
   localparam logic [ADDR_W:0] RG_LO  = (ADDR_W+1)'(REG_BASE);
   localparam logic [ADDR_W:0] RG_END = (ADDR_W+1)'(REG_BASE + 256);
   localparam logic [ADDR_W:0] SR_LO  = (ADDR_W+1)'(SRAM_BASE);

   if (FLASH_BYTES > REG_BASE) begin : g_bad_flash
      $error("flash overlaps the register window");
   end
   if (REG_BASE + 256 > SRAM_BASE) begin : g_bad_sram
      $error("register window overlaps SRAM");
   end
   if ((REG_BASE % 256) != 0) begin : g_bad_align
      $error("register window base must be 256-byte aligned");
   end
   if (SRAM_BYTES < 256) begin : g_bad_small
      $error("SRAM must hold the 256-byte internal data area");
   end

   logic [ADDR_W:0] a;
   assign a = {1'b0, uaddr};

   always_comb begin
      if (a < FL_END)                    region = RG_FLASH;
      else if (a >= RG_LO && a < RG_END) region = RG_REGS;
      else if (a >= SR_LO)               region = RG_SRAM;
      else                               region = RG_NONE;
   end
endmodule

// File: rtl/umd_bus_arb.sv
module umd_bus_arb
   import umd_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   acc_req,
   input  logic   acc_bit,
   input  space_e space,
   input  logic   pf_req,
   output logic   pf_stall,
   output logic   pf_grant
);
   logic bus_claim;
   assign bus_claim = acc_req && !acc_bit && (space == SP_CODE || space == SP_XDATA);
   assign pf_stall  = bus_claim;
   assign pf_grant  = pf_req && !bus_claim;

   AST_ONE_BUS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      !(pf_grant && pf_stall)); // R9
   AST_PF_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pf_stall) && pf_req) |-> pf_grant); // R9
   AST_DATA_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && space == SP_DATA && pf_req) |-> pf_grant); // R9
endmodule

// File: rtl/umd_top.sv
module umd_top
   import umd_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int FLASH_KB = 32,
   parameter int SRAM_KB  = 4,
   parameter int REG_BASE = 16'hDF00,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_req,
   input  logic [1:0]        acc_space,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_indirect,
   input  logic              acc_wr,
   input  logic              acc_bit,
   input  logic              pf_req,
   output logic              pf_stall,
   output logic              pf_grant,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic [1:0]        out_region,
   output logic              out_bit_en,
   output logic [2:0]        out_bit_idx,
   output logic              out_we,
   output logic              out_wr_ignored
);
   localparam int FLASH_BYTES = FLASH_KB * 1024;
   localparam int SRAM_BYTES  = SRAM_KB * 1024;
   localparam logic [ADDR_W:0] FL_END = (ADDR_W+1)'(FLASH_BYTES);

   if (ADDR_W != 16) begin : g_bad_width
      $error("unified map is 16 bits wide");
   end
   if (FLASH_KB != 8 && FLASH_KB != 16 && FLASH_KB != 32) begin : g_bad_fkb
      $error("flash size must be 8, 16 or 32 KB");
   end
   if (SRAM_KB != 1 && SRAM_KB != 2 && SRAM_KB != 4) begin : g_bad_skb
      $error("SRAM size must be 1, 2 or 4 KB");
   end

   space_e            space;
   logic [ADDR_W-1:0] uaddr;
   logic              bit_en;
   logic [2:0]        bit_idx;
   region_e           region;
   logic              blocked;
   logic              we_n;
   logic              ign_n;

   assign space = space_e'(acc_space);

   umd_space_map #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) u_map (
      .clk(clk), .rst_n(rst_n), .req(acc_req), .space(space), .addr(acc_addr),
      .indirect(acc_indirect), .bit_acc(acc_bit),
      .uaddr(uaddr), .bit_en(bit_en), .bit_idx(bit_idx));

   umd_region #(.ADDR_W(ADDR_W), .FLASH_BYTES(FLASH_BYTES), .SRAM_BYTES(SRAM_BYTES),
                .REG_BASE(REG_BASE)) u_region (
      .uaddr(uaddr), .region(region));

   umd_bus_arb u_arb (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_bit(acc_bit), .space(space),
      .pf_req(pf_req), .pf_stall(pf_stall), .pf_grant(pf_grant));

   assign blocked = (region == RG_FLASH);
   assign we_n    = acc_req && acc_wr && !blocked;
   assign ign_n   = acc_req && acc_wr && blocked;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid      <= 1'b0;
            out_addr       <= '0;
            out_region     <= RG_NONE;
            out_bit_en     <= 1'b0;
            out_bit_idx    <= 3'd0;
            out_we         <= 1'b0;
            out_wr_ignored <= 1'b0;
         end else begin
            out_valid      <= acc_req;
            out_addr       <= uaddr;
            out_region     <= region;
            out_bit_en     <= acc_req && bit_en;
            out_bit_idx    <= bit_idx;
            out_we         <= we_n;
            out_wr_ignored <= ign_n;
         end
      end

      AST_FLASH_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_req && acc_wr && !acc_bit && (space == SP_CODE || space == SP_XDATA)
          && ({1'b0, acc_addr} < FL_END)) |=> (out_wr_ignored && !out_we)); // R10
      AST_IGN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         out_wr_ignored |-> $past(acc_req && acc_wr)); // R10
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(acc_req)); // R8
      AST_SRAM_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_req && acc_wr && !acc_bit && space == SP_XDATA && (&acc_addr[ADDR_W-1:ADDR_W-4]))
         |=> (out_we && !out_wr_ignored)); // R11
   end else begin : g_out_comb
      assign out_valid      = acc_req;
      assign out_addr       = uaddr;
      assign out_region     = region;
      assign out_bit_en     = acc_req && bit_en;
      assign out_bit_idx    = bit_idx;
      assign out_we         = we_n;
      assign out_wr_ignored = ign_n;
   end
endmodule

// File: tb/sim_umd_top.sv
module sim_umd_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_req = 1'b0;
   logic [1:0]  acc_space = 2'd0;
   logic [15:0] acc_addr = 16'h0;
   logic        acc_indirect = 1'b0;
   logic        acc_wr = 1'b0;
   logic        acc_bit = 1'b0;
   logic        pf_req = 1'b0;
   logic        pf_stall, pf_grant, out_valid, out_bit_en, out_we, out_wr_ignored;
   logic [15:0] out_addr;
   logic [1:0]  out_region;
   logic [2:0]  out_bit_idx;

   localparam int FLASH_B = 32 * 1024;
   localparam int SRAM_B  = 4 * 1024;
   localparam int REGB    = 16'hDF00;

   typedef struct packed {
      logic        valid;
      logic [15:0] addr;
      logic [1:0]  region;
      logic        ben;
      logic [2:0]  idx;
      logic        we;
      logic        ign;
   } exp_t;

   exp_t  q_exp[$];
   string q_tag[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   always #2 clk = ~clk;

   umd_top u0 (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_space(acc_space),
      .acc_addr(acc_addr), .acc_indirect(acc_indirect), .acc_wr(acc_wr),
      .acc_bit(acc_bit), .pf_req(pf_req), .pf_stall(pf_stall), .pf_grant(pf_grant),
      .out_valid(out_valid), .out_addr(out_addr), .out_region(out_region),
      .out_bit_en(out_bit_en), .out_bit_idx(out_bit_idx), .out_we(out_we),
      .out_wr_ignored(out_wr_ignored));

   function automatic logic [1:0] region_of(int a);
      if (a < FLASH_B) return 2'd1;
      if (a >= REGB && a < REGB + 256) return 2'd3;
      if (a >= 65536 - SRAM_B) return 2'd2;
      return 2'd0;
   endfunction

   function automatic exp_t model(logic [1:0] sp, logic [15:0] a, logic ind, logic wr, logic bt);
      exp_t e;
      int   ua;
      int   b;
      b = int'(a[7:0]);
      e.ben = 1'b0;
      e.idx = 3'd0;
      if (bt) begin
         e.ben = 1'b1;
         e.idx = a[2:0];
         if (b < 128) ua = 16'hFF20 + b / 8;
         else         ua = REGB + (b / 8) * 8;
      end else if (sp == 2'd0 || sp == 2'd3) ua = int'(a);
      else if (sp == 2'd2) ua = REGB + 128 + int'(a[6:0]);
      else if (b >= 128 && !ind) ua = REGB + b;
      else ua = 16'hFF00 + b;
      e.valid  = 1'b1;
      e.addr   = 16'(ua);
      e.region = region_of(ua);
      e.we     = wr && (e.region != 2'd1);
      e.ign    = wr && (e.region == 2'd1);
      return e;
   endfunction

   task automatic check(string tag, string what, int act, int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic drive(string tag, logic [1:0] sp, logic [15:0] a, logic ind,
                        logic wr, logic bt, logic pfr);
      exp_t e;
      logic exp_stall;
      @(negedge clk);
      acc_req = 1'b1; acc_space = sp; acc_addr = a; acc_indirect = ind;
      acc_wr = wr; acc_bit = bt; pf_req = pfr;
      e = model(sp, a, ind, wr, bt);
      q_exp.push_back(e);
      q_tag.push_back(tag);
      #1;
      exp_stall = !bt && (sp == 2'd0 || sp == 2'd3);
      check("R9", "pf_stall", int'(pf_stall), int'(exp_stall));
      check("R9", "pf_grant", int'(pf_grant), int'(pfr && !exp_stall));
   endtask

   task automatic idle(string tag, logic pfr);
      exp_t e;
      @(negedge clk);
      acc_req = 1'b0; acc_wr = 1'b0; acc_bit = 1'b0; pf_req = pfr;
      e = '0;
      q_exp.push_back(e);
      q_tag.push_back(tag);
      #1;
      check("R9", "idle pf_stall", int'(pf_stall), 0);
      check("R9", "idle pf_grant", int'(pf_grant), int'(pfr));
   endtask

   // monitor: pops one expected item per cycle, just after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_exp.size() > 0) begin
            exp_t  e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(e.valid ? t : "R8", "out_valid", int'(out_valid), int'(e.valid));
            check(t, "out_we", int'(out_we), int'(e.we));
            check(t, "out_wr_ignored", int'(out_wr_ignored), int'(e.ign));
            if (e.valid) begin
               check(t, "out_addr", int'(out_addr), int'(e.addr));
               check(t, "out_region", int'(out_region), int'(e.region));
               check(e.ben ? t : "R8", "out_bit_en", int'(out_bit_en), int'(e.ben));
               if (e.ben) check(t, "out_bit_idx", int'(out_bit_idx), int'(e.idx));
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "reset out_valid", int'(out_valid), 0);
      check("R1", "reset out_we", int'(out_we), 0);
      check("R1", "reset out_wr_ignored", int'(out_wr_ignored), 0);
      rst_n = 1'b1;
      idle("R1", 1'b0);
      // R2: code / external data boundaries
      drive("R2", 2'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1);
      drive("R2", 2'd3, 16'h7FFF, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R2", 2'd0, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b1);
      drive("R2", 2'd3, 16'hDEFF, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R2", 2'd3, 16'hDF00, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R2", 2'd0, 16'hDFFF, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R2", 2'd3, 16'hE000, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R2", 2'd3, 16'hEFFF, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R2", 2'd0, 16'hF000, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R2", 2'd3, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1);
      idle("R9", 1'b1);
      // R3 / R4: internal data
      drive("R3", 2'd1, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b1);
      drive("R3", 2'd1, 16'h007F, 1'b1, 1'b0, 1'b0, 1'b0);
      drive("R4", 2'd1, 16'h0090, 1'b1, 1'b0, 1'b0, 1'b0);
      drive("R4", 2'd1, 16'h0090, 1'b0, 1'b0, 1'b0, 1'b1);
      drive("R4", 2'd1, 16'h00FF, 1'b1, 1'b1, 1'b0, 1'b0);
      drive("R4", 2'd1, 16'h0080, 1'b0, 1'b0, 1'b0, 1'b0);
      // R5: register space
      drive("R5", 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
      drive("R5", 2'd2, 16'h007F, 1'b0, 1'b1, 1'b0, 1'b1);
      idle("R8", 1'b0);
      // R6 / R7: bit accesses, space and indirect set to unrelated values
      drive("R6", 2'd3, 16'h1200, 1'b1, 1'b0, 1'b1, 1'b1);
      drive("R6", 2'd0, 16'h007F, 1'b0, 1'b1, 1'b1, 1'b0);
      drive("R6", 2'd1, 16'h003A, 1'b0, 1'b0, 1'b1, 1'b0);
      drive("R7", 2'd2, 16'h0080, 1'b0, 1'b0, 1'b1, 1'b0);
      drive("R7", 2'd1, 16'h00E7, 1'b1, 1'b1, 1'b1, 1'b1);
      drive("R7", 2'd3, 16'h00FF, 1'b0, 1'b0, 1'b1, 1'b0);
      // R10 / R11: writes
      drive("R10", 2'd3, 16'h1234, 1'b0, 1'b1, 1'b0, 1'b1);
      idle("R10", 1'b0);
      drive("R10", 2'd0, 16'h0010, 1'b0, 1'b1, 1'b0, 1'b0);
      drive("R10", 2'd3, 16'h7FFF, 1'b0, 1'b1, 1'b0, 1'b0);
      drive("R11", 2'd3, 16'hF100, 1'b0, 1'b1, 1'b0, 1'b0);
      drive("R11", 2'd3, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b0);
      drive("R11", 2'd3, 16'hDF40, 1'b0, 1'b1, 1'b0, 1'b1);
      drive("R11", 2'd1, 16'h0030, 1'b1, 1'b1, 1'b0, 1'b0);
      drive("R11", 2'd3, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0);
      idle("R8", 1'b1);
      idle("R8", 1'b0);
      wait (q_exp.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R8 actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule